// File: doc/BRIEF.md
# Multi-Mode Motor PWM Channel

This block is one output channel of a motor controller. A free-running timer counter with a programmable period drives a comparator. The comparator turns a duty value into a pulse that is left, right or center aligned. The pulse then passes through a short programmable delay line. Last, a steering stage maps it onto two pins, a minus side and a plus side, each with its own output enable, so that the channel can drive half, full or dual full H-bridge arrangements.

Software programs the channel through a simple write port and a registered read port. The port reaches three registers: control, duty and period. The alignment and output-mode fields of the control register pass through a shadow copy. They take effect at once only when the channel cannot glitch: when the period is zero, or when this channel and all its peers are idle. Otherwise they wait for the next counter wrap. The delay field and the duty value take effect at once.

Top module: `mc_pwm_channel`

## Requirements
- R1: Control register layout: bits 7:6 output mode, bits 5:4 alignment, bits 3:2 reserved, bits 1:0 delay. Address 0 is control, 1 is duty and 2 is period. A read returns the most recently written value one cycle after `rd_addr` is applied, with bits 3:2 always zero, even while the working copy differs.
- R2: Alignment 01 (left): the pulse is active while the counter is below the duty value.
- R3: Alignment 10 (right): the pulse is active while counter plus duty is at least the period, so it ends at the period end.
- R4: Alignment 11 (center): with the counter folded into a triangle, f = min(count, period-1-count), the pulse is active while 2*f is below the duty value.
- R5: The counter runs from 0 to period-1 and wraps. Duty 0 gives a constantly inactive pulse, and duty at or above the period gives a constantly active one. A period of 0 holds the counter at 0 and keeps the pulse inactive.
- R6: Output mode 00 puts the pulse on the minus pin and releases the plus pin. Mode 01 puts it on the plus pin and releases the minus pin. Mode 10 puts it on the plus pin and its complement on the minus pin. Mode 11 puts it on both pins in phase.
- R7: A released pin has its enable low and its value low. With working alignment 00, both pins are released.
- R8: A written alignment or output mode enters the working copy on the cycle after a counter wrap, and otherwise stays pending.
- R9: A written alignment or output mode enters the working copy on the next cycle when the period is 0, or when `peers_off` is high and the working alignment is 00.
- R10: The delay field d (0 to 3) applies at once and shifts the pin waveform by d clocks. The pins show the pulse for the counter value held 2+d cycles earlier.
- R11: Synchronous reset clears every register, the counter and all pin outputs and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timer advances once per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 duty, 2 period) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Registered read data |
| peers_off | input | 1 | High when every other channel is disabled |
| pwm_m | output | 1 | Minus-side pin value |
| pwm_m_oe | output | 1 | Minus-side pin enable |
| pwm_p | output | 1 | Plus-side pin value |
| pwm_p_oe | output | 1 | Plus-side pin enable |

## Verification
The bench sweeps every alignment, output mode, delay and duty from 0 to period+1 over periods of 1, 4 and 7. This reaches the duty-0 and duty-at-or-above-period extremes where an off-by-one comparator would emit a one-cycle glitch. The sweep also reaches the period-1 case, where the center fold and the right-aligned sum are easiest to get wrong. Mode changes are issued both with peers active and with peers idle. It also covers a zero period, which separates waiting for a wrap from loading at once: a design that loaded at once would switch patterns mid-period, and one that never loaded at once would stay stuck with a zero period. Every pin value and enable is compared on every cycle, so a delay tap that is off by one, or a released pin left driving, shows up as a mismatch.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  typedef enum logic [1:0] {
    AL_OFF    = 2'b00,
    AL_LEFT   = 2'b01,
    AL_RIGHT  = 2'b10,
    AL_CENTER = 2'b11
  } align_e;

  typedef enum logic [1:0] {
    OM_HALF_M = 2'b00,
    OM_HALF_P = 2'b01,
    OM_FULL   = 2'b10,
    OM_DUAL   = 2'b11
  } omode_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DUTY = 2'd1;
  localparam logic [1:0] A_PER  = 2'd2;
  localparam int         DLY_W  = 2;
endpackage

// File: rtl/mcp_timer.sv
module mcp_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  // Wrap at period-1; a shrunken period wraps on the next cycle.
  assign ovf = (per != '0) && (cnt >= per - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (per == '0 || ovf) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mcp_regs.sv
module mcp_regs
  import mcp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  input  logic             peers_off,
  input  logic             ovf,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] duty,
  output logic [CNT_W-1:0] per,
  output logic [DLY_W-1:0] dly,
  output align_e           work_al,
  output omode_e           work_om,
  output logic             imm
);
  align_e sh_al;
  omode_e sh_om;

  // Loading at once is safe only when nothing is being generated.
  assign imm = (peers_off && work_al == AL_OFF) || (per == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_al   <= AL_OFF;
      sh_om   <= OM_HALF_M;
      dly     <= '0;
      duty    <= '0;
      per     <= '0;
      work_al <= AL_OFF;
      work_om <= OM_HALF_M;
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: begin
            sh_om <= omode_e'(wr_data[7:6]);
            sh_al <= align_e'(wr_data[5:4]);
            dly   <= wr_data[DLY_W-1:0];
          end
          A_DUTY:  duty <= wr_data;
          A_PER:   per  <= wr_data;
          default: ;
        endcase
      end
      if (imm || ovf) begin
        work_al <= sh_al;
        work_om <= sh_om;
      end
      case (rd_addr)
        A_CTRL:  rd_data <= CNT_W'({sh_om, sh_al, 2'b00, dly});
        A_DUTY:  rd_data <= duty;
        A_PER:   rd_data <= per;
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mcp_compare.sv
module mcp_compare
  import mcp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] duty,
  input  align_e           al,
  output logic             pwm_q
);
  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] rem, fold;
  logic             act;

  always_comb begin
    rem  = per - 1'b1 - cnt;
    fold = (cnt < rem) ? cnt : rem;
    act  = 1'b0;
    if (per != '0) begin
      case (al)
        AL_LEFT:   act = cnt < duty;
        AL_RIGHT:  act = (EW'(cnt) + EW'(duty)) >= EW'(per);
        AL_CENTER: act = {fold, 1'b0} < EW'(duty);
        default:   act = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= act;
  end
endmodule

// File: rtl/mcp_delay.sv
module mcp_delay #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  localparam int DEPTH = (1 << SEL_W) - 1;

  logic [DEPTH-1:0] sr;
  logic [DEPTH:0]   taps;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[DEPTH-2:0], din};
  end

  assign taps = {sr, din};
  assign dout = taps[sel];
endmodule

// File: rtl/mc_pwm_channel.sv
module mc_pwm_channel
  import mcp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             peers_off,
  output logic             pwm_m,
  output logic             pwm_m_oe,
  output logic             pwm_p,
  output logic             pwm_p_oe
);
  logic [CNT_W-1:0] cnt, duty, per;
  logic [DLY_W-1:0] dly;
  logic             ovf, imm, pwm_q, tap;
  align_e           work_al;
  omode_e           work_om;

  mcp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .per(per), .cnt(cnt), .ovf(ovf)
  );

  mcp_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .peers_off(peers_off),
    .ovf(ovf), .rd_data(rd_data), .duty(duty), .per(per), .dly(dly),
    .work_al(work_al), .work_om(work_om), .imm(imm)
  );

  mcp_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .cnt(cnt), .per(per), .duty(duty),
    .al(work_al), .pwm_q(pwm_q)
  );

  mcp_delay #(.SEL_W(DLY_W)) u_dly (
    .clk(clk), .rst(rst), .din(pwm_q), .sel(dly), .dout(tap)
  );

  always_ff @(posedge clk) begin
    if (rst || work_al == AL_OFF) begin
      {pwm_m, pwm_m_oe, pwm_p, pwm_p_oe} <= 4'b0000;
    end else begin
      case (work_om)
        OM_HALF_M: {pwm_m, pwm_m_oe, pwm_p, pwm_p_oe} <= {tap, 1'b1, 1'b0, 1'b0};
        OM_HALF_P: {pwm_m, pwm_m_oe, pwm_p, pwm_p_oe} <= {1'b0, 1'b0, tap, 1'b1};
        OM_FULL:   {pwm_m, pwm_m_oe, pwm_p, pwm_p_oe} <= {~tap, 1'b1, tap, 1'b1};
        default:   {pwm_m, pwm_m_oe, pwm_p, pwm_p_oe} <= {tap, 1'b1, tap, 1'b1};
      endcase
    end
  end
endmodule

// File: rtl/mcp_checker.sv
module mcp_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pwm_m,
  input logic             pwm_m_oe,
  input logic             pwm_p,
  input logic             pwm_p_oe,
  input logic [1:0]       work_al,
  input logic [1:0]       work_om,
  input logic             ovf,
  input logic             imm,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       rd_addr,
  input logic [CNT_W-1:0] rd_data
);
  a_r7_minus_released_low: assert property (@(posedge clk) disable iff (rst)
    !pwm_m_oe |-> !pwm_m);

  a_r7_plus_released_low: assert property (@(posedge clk) disable iff (rst)
    !pwm_p_oe |-> !pwm_p);

  a_r7_disabled_released: assert property (@(posedge clk) disable iff (rst)
    (work_al == 2'b00) |=> (!pwm_m_oe && !pwm_p_oe));

  a_r6_full_complement: assert property (@(posedge clk) disable iff (rst)
    (work_om == 2'b10 && work_al != 2'b00) |=> (pwm_m_oe && pwm_p_oe && pwm_m != pwm_p));

  a_r8_working_hold: assert property (@(posedge clk) disable iff (rst)
    !(ovf || imm) |=> ($stable(work_al) && $stable(work_om)));

  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt == '0));

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == 2'b00) |=> (rd_data[3:2] == 2'b00));
endmodule

bind mc_pwm_channel mcp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .pwm_m(pwm_m), .pwm_m_oe(pwm_m_oe),
  .pwm_p(pwm_p), .pwm_p_oe(pwm_p_oe), .work_al(work_al),
  .work_om(work_om), .ovf(ovf), .imm(imm), .cnt(cnt),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_mc_pwm_channel.sv
`timescale 1ns/1ps
module tb_mc_pwm_channel;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [1:0]       rd_addr = '0;
  logic [CNT_W-1:0] rd_data;
  logic             peers_off = 1'b1;
  logic             pwm_m, pwm_m_oe, pwm_p, pwm_p_oe;

  mc_pwm_channel #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .peers_off(peers_off),
    .pwm_m(pwm_m), .pwm_m_oe(pwm_m_oe), .pwm_p(pwm_p), .pwm_p_oe(pwm_p_oe)
  );

  always #2.5 clk = ~clk;

  int    checks = 0, errors = 0;
  bit    chk_on = 1'b0, done = 1'b0;
  string phase = "init";

  // Behavioural model built from the requirements.
  int m_cnt, m_per, m_duty, s_al, s_om, m_dly, w_al, w_om, p_al, p_om, p_d;
  logic [7:0] hist;

  function automatic bit act_f(int c, int a, int d, int p);
    int b, fo;
    if (p == 0 || a == 0) return 1'b0;
    case (a)
      1: return c < d;
      2: return (c + d) >= p;
      default: begin
        b  = p - 1 - c;
        fo = (b < 0) ? c : ((c < b) ? c : b);
        return (2 * fo) < d;
      end
    endcase
  endfunction

  function automatic logic [3:0] steer_f(bit t, int a, int om);
    if (a == 0) return 4'b0000;
    case (om)
      0: return {t, 1'b1, 1'b0, 1'b0};
      1: return {1'b0, 1'b0, t, 1'b1};
      2: return {~t, 1'b1, t, 1'b1};
      default: return {t, 1'b1, t, 1'b1};
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_per <= 0; m_duty <= 0; s_al <= 0; s_om <= 0; m_dly <= 0;
      w_al <= 0; w_om <= 0; p_al <= 0; p_om <= 0; p_d <= 0; hist <= '0;
    end else begin
      hist <= {hist[6:0], act_f(m_cnt, w_al, m_duty, m_per)};
      p_al <= w_al; p_om <= w_om; p_d <= m_dly;
      if (m_per == 0 || m_cnt >= m_per - 1) m_cnt <= 0;
      else m_cnt <= m_cnt + 1;
      if ((peers_off && w_al == 0) || m_per == 0 || (m_per != 0 && m_cnt >= m_per - 1)) begin
        w_al <= s_al; w_om <= s_om;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin s_om <= int'(wr_data[7:6]); s_al <= int'(wr_data[5:4]); m_dly <= int'(wr_data[1:0]); end
          2'd1: m_duty <= int'(wr_data);
          2'd2: m_per <= int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  // Continuous pin comparison (R2..R10 depending on phase).
  always @(negedge clk) begin
    if (!rst && chk_on && !done) begin
      logic [3:0] exp_v, act_v;
      exp_v = steer_f(hist[1 + p_d], p_al, p_om);
      act_v = {pwm_m, pwm_m_oe, pwm_p, pwm_p_oe};
      checks++;
      if (act_v !== exp_v) begin
        errors++;
        $display("FAIL %s: pins {m,m_oe,p,p_oe} actual=%b expected=%b (al=%0d om=%0d d=%0d duty=%0d per=%0d)",
                 phase, act_v, exp_v, p_al, p_om, p_d, m_duty, m_per);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [CNT_W-1:0] exp_v, input string tag);
    @(negedge clk); rd_addr = a;
    @(negedge clk);
    checks++;
    if (rd_data !== exp_v) begin
      errors++;
      $display("FAIL %s: read addr %0d actual=%h expected=%h", tag, a, rd_data, exp_v);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finish_up();
  end

  initial begin
    int pers[3] = '{1, 4, 7};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    checks++;
    if ({pwm_m, pwm_m_oe, pwm_p, pwm_p_oe} !== 4'b0000) begin
      errors++;
      $display("FAIL R11: pins actual=%b expected=0000", {pwm_m, pwm_m_oe, pwm_p, pwm_p_oe});
    end
    rd_chk(2'd0, 8'h00, "R11 ctrl reset");
    rd_chk(2'd1, 8'h00, "R11 duty reset");
    rd_chk(2'd2, 8'h00, "R11 period reset");
    chk_on = 1'b1;

    phase = "R1 readback";
    wr(2'd0, 8'hFF); rd_chk(2'd0, 8'hF3, "R1 reserved bits");
    wr(2'd1, 8'h5A); rd_chk(2'd1, 8'h5A, "R1 duty");
    wr(2'd0, 8'h00); run(3);

    phase = "R5 zero period";
    wr(2'd0, 8'h91); wr(2'd1, 8'd3); run(10);

    foreach (pers[i]) begin
      peers_off = (pers[i] != 4);
      wr(2'd2, CNT_W'(pers[i]));
      for (int al = 0; al < 4; al++)
        for (int om = 0; om < 4; om++)
          for (int d = 0; d < 4; d++)
            for (int du = 0; du <= pers[i] + 1; du++) begin
              phase = peers_off ? "R2 R3 R4 R5 R6 R7 R10 sweep"
                                : "R8 R2 R3 R4 R6 R10 sweep with peers active";
              wr(2'd0, CNT_W'({om[1:0], al[1:0], 2'b00, d[1:0]}));
              wr(2'd1, CNT_W'(du));
              run(2 * pers[i] + 6);
            end
    end

    phase = "R8 pending until wrap";
    peers_off = 1'b1;
    wr(2'd2, 8'd9); wr(2'd1, 8'd4); wr(2'd0, 8'h90); run(20);
    wr(2'd0, 8'hA0);
    rd_chk(2'd0, 8'hA0, "R1 R8 read returns written value");
    run(20);

    phase = "R9 immediate load when idle";
    wr(2'd0, 8'h00); run(12);
    wr(2'd0, 8'h52); run(20);
    phase = "R9 no immediate load with peers active";
    wr(2'd0, 8'h00); run(12);
    peers_off = 1'b0;
    wr(2'd0, 8'h63); run(25);
    phase = "R9 zero period loads at once";
    wr(2'd2, 8'd0); wr(2'd0, 8'hB1); run(8);

    chk_on = 1'b0;
    run(2);
    finish_up();
  end
endmodule